// File: doc/BRIEF.md
# Multi-lane receive-only serial sampler

This block drives one group of converters that all share a single chip-select and a single serial clock, while each converter returns its sample on a separate data lane. A start request comes from a hardware pulse, a software pulse, or the continuous-mode input. The block then runs a burst of conversions. For each conversion it pulls chip-select low and waits a set number of setup cycles. It then clocks one sample word in from every lane at once, waits a set number of hold cycles, and raises chip-select again. Between conversions it leaves a set idle gap.

The serial clock is made from the system clock. Its half-period lasts `cfg_clk_div + 1` system cycles, and its polarity and phase can be changed at run time for all lanes together. Data travels only from the converters into the block. When the converters are in a low-power state, the `unavailable` input blocks every start request. While the block is idle, software can drive chip-select and the serial clock by hand. This is how power-down sequences are issued to the converters.

Top module: `spi_rx_sampler`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `spi_cs_n` is 1, `busy` is 0, `raw_valid` is 0 and `spi_sclk` equals `cfg_cpol`.
- R2: Each serial clock half-period lasts `cfg_clk_div+1` cycles. The clock rests at `cfg_cpol`, toggles exactly 2·WORD_W times per conversion, and toggles only while chip-select is low.
- R3: Every lane captures WORD_W bits, most significant bit first. With `cfg_cpha`=0 it samples on the edge leaving the rest level; with `cfg_cpha`=1 it samples on the edge returning to it. Lane l appears in `raw_data[l*WORD_W +: WORD_W]`.
- R4: Chip-select stays low for `cfg_pre_dly+1` cycles before the first half-period starts. It rises `cfg_post_dly+1` cycles after the last clock edge.
- R5: One start request runs `cfg_burst_len` conversions, and a value of 0 runs one conversion. Between conversions, chip-select stays high for `cfg_gap+1` cycles.
- R6: While `mode_continuous` is 1, a new burst starts after one idle cycle without any pulse.
- R7: A pulse on `hw_trig` or `sw_trig` in an idle cycle is accepted on that clock edge, and chip-select falls in the next cycle.
- R8: While `unavailable` is 1, no start request of any kind is accepted.
- R9: A start pulse that arrives while a burst is running is dropped and does not extend the burst.
- R10: When idle and `man_en`=1, `man_cs_n` and `man_sclk` appear on the pins one cycle later. While busy, these inputs have no effect.
- R11: `raw_valid` is a one-cycle pulse in the cycle when chip-select rises after each conversion. In that same cycle, `raw_data` holds the words from that conversion.
- R12: `busy` rises in the cycle after acceptance and stays high until the cycle of the final `raw_valid`, where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clk_div | input | DIV_W | Half-period length minus one, in cycles |
| cfg_cpol | input | 1 | Serial clock rest level |
| cfg_cpha | input | 1 | 0: sample on leaving edge, 1: on returning edge |
| cfg_pre_dly | input | DLY_W | Setup cycles minus one after chip-select falls |
| cfg_post_dly | input | DLY_W | Hold cycles minus one before chip-select rises |
| cfg_gap | input | GAP_W | Idle cycles minus one between conversions of a burst |
| cfg_burst_len | input | BURST_W | Conversions per start request (0 means 1) |
| mode_continuous | input | 1 | Restart bursts without a pulse |
| hw_trig | input | 1 | Hardware start pulse |
| sw_trig | input | 1 | Software start pulse |
| unavailable | input | 1 | Converters asleep; blocks every start |
| man_en | input | 1 | Hand control of the pins while idle |
| man_cs_n | input | 1 | Hand-driven chip-select level |
| man_sclk | input | 1 | Hand-driven serial clock level |
| spi_cs_n | output | 1 | Shared chip-select, active low |
| spi_sclk | output | 1 | Shared serial clock |
| spi_miso | input | LANES | One data lane per converter |
| raw_data | output | LANES*WORD_W | Captured words, lane 0 in the low bits |
| raw_valid | output | 1 | One-cycle pulse when a conversion ends |
| busy | output | 1 | A burst is in progress |

## Verification
The assertions assume that polarity, phase, divider and delay settings stay constant while `busy` is high, since the rest-level checks compare the clock against the live `cfg_cpol`. They also assume that every data lane changes only in response to pin edges, and never in the same cycle as the capturing edge. The stimulus changes configuration only in idle cycles. Its converter model updates the lanes on the falling system-clock edge, and only after the shifting serial edge of the chosen mode, so every captured bit has been stable for at least one whole cycle.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_SHIFT = 3'd2,
    ST_POST  = 3'd3,
    ST_GAP   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/spi_rx_clkgen.sv
// Half-period timer and edge classifier for the shared serial clock.
module spi_rx_clkgen #(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cpha,
  output logic             tick,
  output logic             sample,
  output logic             last
);
  localparam int HALVES = 2 * WORD_W;
  localparam int HC_W   = $clog2(HALVES);

  logic [DIV_W-1:0] div_cnt;
  logic [HC_W-1:0]  half_cnt;

  // a tick ends a half-period; even halves end on a leaving edge
  assign tick   = run && (div_cnt == clk_div);
  assign sample = tick && (half_cnt[0] == cpha);
  assign last   = tick && (half_cnt == HC_W'(HALVES - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_cnt  <= '0;
      half_cnt <= '0;
    end else if (tick) begin
      div_cnt  <= '0;
      half_cnt <= half_cnt + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  // R3: after the final edge the sequencer stops the clock
  p_stop_after_last_r3: assert property (@(posedge clk) disable iff (rst)
    last |=> !run);
endmodule

// File: rtl/spi_rx_lane.sv
// One data lane: shift register plus registered output word.
module spi_rx_lane #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miso,
  input  logic              sample,
  input  logic              load,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      word  <= '0;
    end else begin
      if (sample) shreg <= {shreg[WORD_W-2:0], miso};
      if (load)   word  <= shreg;
    end
  end
endmodule

// File: rtl/spi_rx_seq.sv
// Conversion sequencer: start qualification, delays, burst and gap counting.
module spi_rx_seq
  import spi_rx_pkg::*;
#(
  parameter int DLY_W   = 8,
  parameter int GAP_W   = 12,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hw_trig,
  input  logic               sw_trig,
  input  logic               cont,
  input  logic               unavail,
  input  logic               man_en,
  input  logic               man_cs_n,
  input  logic [DLY_W-1:0]   pre_dly,
  input  logic [DLY_W-1:0]   post_dly,
  input  logic [GAP_W-1:0]   gap,
  input  logic [BURST_W-1:0] burst_len,
  input  logic               last_tick,
  output seq_state_t         state,
  output logic               accept,
  output logic               load,
  output logic               cs_n,
  output logic               busy,
  output logic               valid
);
  localparam int TW = (DLY_W > GAP_W) ? DLY_W : GAP_W;

  logic [TW-1:0]      dcnt;
  logic [BURST_W-1:0] left;

  assign accept = (state == ST_IDLE) && (hw_trig || sw_trig || cont) && !unavail;
  assign load   = (state == ST_POST) && (dcnt == TW'(post_dly));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      dcnt  <= '0;
      left  <= '0;
      cs_n  <= 1'b1;
      busy  <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          cs_n <= man_en ? man_cs_n : 1'b1;
          if (accept) begin
            state <= ST_PRE;
            dcnt  <= '0;
            cs_n  <= 1'b0;
            busy  <= 1'b1;
            left  <= (burst_len == '0) ? '0 : burst_len - 1'b1;
          end
        end
        ST_PRE: begin
          if (dcnt == TW'(pre_dly)) begin
            state <= ST_SHIFT;
            dcnt  <= '0;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (last_tick) begin
            state <= ST_POST;
            dcnt  <= '0;
          end
        end
        ST_POST: begin
          if (load) begin
            cs_n  <= 1'b1;
            valid <= 1'b1;
            dcnt  <= '0;
            if (left == '0) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
            end else begin
              state <= ST_GAP;
              left  <= left - 1'b1;
            end
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (dcnt == TW'(gap)) begin
            state <= ST_PRE;
            dcnt  <= '0;
            cs_n  <= 1'b0;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: completion flag lasts one cycle
  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R8: an unavailable converter group never leaves idle
  p_unavail_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && unavail) |=> (state == ST_IDLE));
  // R6: continuous mode restarts straight from idle
  p_cont_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && cont && !unavail) |=> (state == ST_PRE));
  // R4: chip-select is held low across the shifting window
  p_cs_low_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |-> !cs_n);
  // R9: remaining-conversion count only moves at conversion end
  p_burst_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && state != ST_POST) |=> $stable(left));
endmodule

// File: rtl/spi_rx_sampler.sv
module spi_rx_sampler
  import spi_rx_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int WORD_W  = 16,
  parameter int DIV_W   = 8,
  parameter int DLY_W   = 8,
  parameter int GAP_W   = 12,
  parameter int BURST_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DIV_W-1:0]          cfg_clk_div,
  input  logic                      cfg_cpol,
  input  logic                      cfg_cpha,
  input  logic [DLY_W-1:0]          cfg_pre_dly,
  input  logic [DLY_W-1:0]          cfg_post_dly,
  input  logic [GAP_W-1:0]          cfg_gap,
  input  logic [BURST_W-1:0]        cfg_burst_len,
  input  logic                      mode_continuous,
  input  logic                      hw_trig,
  input  logic                      sw_trig,
  input  logic                      unavailable,
  input  logic                      man_en,
  input  logic                      man_cs_n,
  input  logic                      man_sclk,
  output logic                      spi_cs_n,
  output logic                      spi_sclk,
  input  logic [LANES-1:0]          spi_miso,
  output logic [LANES*WORD_W-1:0]   raw_data,
  output logic                      raw_valid,
  output logic                      busy
);
  seq_state_t state;
  logic       accept, load, tick, sample, last;
  logic       run;

  assign run = (state == ST_SHIFT);

  spi_rx_seq #(
    .DLY_W  (DLY_W),
    .GAP_W  (GAP_W),
    .BURST_W(BURST_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .hw_trig  (hw_trig),
    .sw_trig  (sw_trig),
    .cont     (mode_continuous),
    .unavail  (unavailable),
    .man_en   (man_en),
    .man_cs_n (man_cs_n),
    .pre_dly  (cfg_pre_dly),
    .post_dly (cfg_post_dly),
    .gap      (cfg_gap),
    .burst_len(cfg_burst_len),
    .last_tick(last),
    .state    (state),
    .accept   (accept),
    .load     (load),
    .cs_n     (spi_cs_n),
    .busy     (busy),
    .valid    (raw_valid)
  );

  spi_rx_clkgen #(
    .WORD_W(WORD_W),
    .DIV_W (DIV_W)
  ) u_clkgen (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .clk_div(cfg_clk_div),
    .cpha   (cfg_cpha),
    .tick   (tick),
    .sample (sample),
    .last   (last)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    spi_rx_lane #(.WORD_W(WORD_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .miso  (spi_miso[g]),
      .sample(sample),
      .load  (load),
      .word  (raw_data[g*WORD_W +: WORD_W])
    );
  end

  // serial clock pin: toggles while shifting, hand-driven when idle, else rests
  always_ff @(posedge clk) begin
    if (rst) begin
      spi_sclk <= cfg_cpol;
    end else if (state == ST_SHIFT) begin
      if (tick) spi_sclk <= ~spi_sclk;
    end else if (state == ST_IDLE && !accept && man_en) begin
      spi_sclk <= man_sclk;
    end else begin
      spi_sclk <= cfg_cpol;
    end
  end

  // R2: a burst moves the clock only inside a chip-select window
  p_sclk_framed_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !$stable(spi_sclk)) |-> !spi_cs_n);
  // R2: the clock rests at its polarity in the setup and hold windows
  p_rest_level_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE || state == ST_POST) |-> (spi_sclk == cfg_cpol));
  // R12: a burst always opens with chip-select low
  p_start_selects_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !spi_cs_n);
endmodule

// File: tb/spi_rx_sampler_bench.sv
module spi_rx_sampler_bench;
  localparam int LANES = 4, WORD_W = 16, DIV_W = 8, DLY_W = 8, GAP_W = 12, BURST_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [DIV_W-1:0] cfg_clk_div = '0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [DLY_W-1:0] cfg_pre_dly = '0, cfg_post_dly = '0;
  logic [GAP_W-1:0] cfg_gap = '0;
  logic [BURST_W-1:0] cfg_burst_len = 8'd1;
  logic mode_continuous = 1'b0, hw_trig = 1'b0, sw_trig = 1'b0, unavailable = 1'b0;
  logic man_en = 1'b0, man_cs_n = 1'b1, man_sclk = 1'b0;
  logic spi_cs_n, spi_sclk, raw_valid, busy;
  logic [LANES-1:0] spi_miso = '0;
  logic [LANES*WORD_W-1:0] raw_data;

  spi_rx_sampler #(
    .LANES(LANES), .WORD_W(WORD_W), .DIV_W(DIV_W),
    .DLY_W(DLY_W), .GAP_W(GAP_W), .BURST_W(BURST_W)
  ) u_spi_rx_sampler (
    .clk(clk), .rst(rst), .cfg_clk_div(cfg_clk_div), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_pre_dly(cfg_pre_dly), .cfg_post_dly(cfg_post_dly),
    .cfg_gap(cfg_gap), .cfg_burst_len(cfg_burst_len),
    .mode_continuous(mode_continuous), .hw_trig(hw_trig), .sw_trig(sw_trig),
    .unavailable(unavailable), .man_en(man_en), .man_cs_n(man_cs_n),
    .man_sclk(man_sclk), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_miso(spi_miso), .raw_data(raw_data), .raw_valid(raw_valid), .busy(busy)
  );

  int checks = 0, failures = 0;
  string tag = "R1";

  typedef struct {
    logic busy;
    logic cs;
    logic sclk;
    logic valid;
  } obs_t;

  obs_t q[$];
  bit   last_idle = 1'b1;
  logic idle_cs = 1'b1, idle_sclk = 1'b0;
  int   vcount = 0;

  // behavioural converter group
  logic [WORD_W-1:0] adc_word [LANES];
  int   seed = 0, bit_idx = -1;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (prev_cs && !spi_cs_n) begin
      seed = seed + 1;
      for (int l = 0; l < LANES; l++)
        adc_word[l] = WORD_W'((seed * 947 + l * 4951) ^ 32'hA5C3);
      bit_idx = cfg_cpha ? WORD_W : WORD_W - 1;
    end else if (!spi_cs_n && spi_sclk !== prev_sclk) begin
      if ((prev_sclk == cfg_cpol) == (cfg_cpha == 1'b1)) bit_idx = bit_idx - 1;
    end
    for (int l = 0; l < LANES; l++)
      spi_miso[l] = (bit_idx >= 0 && bit_idx < WORD_W) ? adc_word[l][bit_idx] : 1'b0;
    prev_cs   = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  function automatic obs_t mk(input logic b, input logic c, input logic s, input logic v);
    obs_t o;
    o.busy = b; o.cs = c; o.sclk = s; o.valid = v;
    return o;
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_burst();
    int n;
    n = (cfg_burst_len == 0) ? 1 : int'(cfg_burst_len);
    for (int c = 0; c < n; c++) begin
      for (int i = 0; i <= int'(cfg_pre_dly); i++) q.push_back(mk(1, 0, cfg_cpol, 0));
      for (int h = 0; h < 2 * WORD_W; h++)
        for (int k = 0; k <= int'(cfg_clk_div); k++)
          q.push_back(mk(1, 0, cfg_cpol ^ logic'(h % 2), 0));
      for (int i = 0; i <= int'(cfg_post_dly); i++) q.push_back(mk(1, 0, cfg_cpol, 0));
      if (c < n - 1)
        for (int i = 0; i <= int'(cfg_gap); i++) q.push_back(mk(1, 1, cfg_cpol, logic'(i == 0)));
      else
        q.push_back(mk(0, 1, cfg_cpol, 1));
    end
  endtask

  // one clock of the reference model, compared at the following falling edge
  task automatic step();
    obs_t e;
    if (last_idle) begin
      if ((hw_trig || sw_trig || mode_continuous) && !unavailable) push_burst();
      else begin
        idle_cs   = man_en ? man_cs_n : 1'b1;
        idle_sclk = man_en ? man_sclk : cfg_cpol;
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else e = mk(0, idle_cs, idle_sclk, 0);
    chk("R12 busy", 64'(busy), 64'(e.busy));
    chk("R4 cs_n", 64'(spi_cs_n), 64'(e.cs));
    chk("R2 sclk", 64'(spi_sclk), 64'(e.sclk));
    chk("R11 valid", 64'(raw_valid), 64'(e.valid));
    if (raw_valid) vcount++;
    if (e.valid)
      for (int l = 0; l < LANES; l++)
        chk("R3 lane word", 64'(raw_data[l*WORD_W +: WORD_W]), 64'(adc_word[l]));
    last_idle = !e.busy;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (!(q.size() == 0 && last_idle) && guard < 20000) begin
      step();
      guard++;
    end
    step();
  endtask

  task automatic pulse_hw();
    hw_trig = 1'b1; step(); hw_trig = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 cs_n", 64'(spi_cs_n), 64'd1);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 valid", 64'(raw_valid), 64'd0);
    chk("R1 sclk", 64'(spi_sclk), 64'(cfg_cpol));
    rst = 1'b0;
    repeat (2) step();

    // R7: hardware pulse, mode 0, fastest clock
    tag = "R7"; vcount = 0;
    pulse_hw(); wait_idle();
    chk("R7 conversions", 64'(vcount), 64'd1);

    // R5: software pulse, burst of three with gaps, polarity 1 phase 1
    tag = "R5"; vcount = 0;
    cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_clk_div = 8'd2;
    cfg_pre_dly = 8'd3; cfg_post_dly = 8'd2; cfg_gap = 12'd4; cfg_burst_len = 8'd3;
    repeat (2) step();
    sw_trig = 1'b1; step(); sw_trig = 1'b0;
    wait_idle();
    chk("R5 conversions", 64'(vcount), 64'd3);

    // R9: extra pulse during a burst is dropped
    tag = "R9"; vcount = 0;
    cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_clk_div = 8'd1; cfg_burst_len = 8'd2;
    cfg_pre_dly = 8'd0; cfg_post_dly = 8'd1; cfg_gap = 12'd0;
    step();
    pulse_hw();
    repeat (20) step();
    pulse_hw();
    wait_idle();
    chk("R9 conversions", 64'(vcount), 64'd2);

    // R8: unavailable blocks both pulse sources and continuous mode
    tag = "R8"; vcount = 0;
    unavailable = 1'b1;
    pulse_hw();
    sw_trig = 1'b1; step(); sw_trig = 1'b0;
    mode_continuous = 1'b1; repeat (5) step(); mode_continuous = 1'b0;
    repeat (5) step();
    chk("R8 conversions", 64'(vcount), 64'd0);
    chk("R8 busy", 64'(busy), 64'd0);
    unavailable = 1'b0;

    // R10: hand control in idle, ignored while busy
    tag = "R10"; vcount = 0; cfg_burst_len = 8'd1;
    man_en = 1'b1; man_cs_n = 1'b0; man_sclk = 1'b1;
    repeat (3) step();
    man_sclk = 1'b0; step();
    man_cs_n = 1'b1; step();
    pulse_hw();
    for (int i = 0; i < 40; i++) begin
      man_cs_n = logic'(i % 2);
      man_sclk = logic'((i / 3) % 2);
      step();
    end
    wait_idle();
    chk("R10 conversions", 64'(vcount), 64'd1);
    man_en = 1'b0; man_cs_n = 1'b1; step();

    // R6: continuous mode
    tag = "R6"; vcount = 0;
    cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_clk_div = 8'd0;
    cfg_pre_dly = 8'd1; cfg_post_dly = 8'd1; cfg_gap = 12'd1; cfg_burst_len = 8'd2;
    step();
    mode_continuous = 1'b1;
    repeat (300) step();
    mode_continuous = 1'b0;
    wait_idle();
    chk("R6 enough conversions", 64'(vcount >= 6), 64'd1);

    // R5: zero burst length runs one conversion
    tag = "R5"; vcount = 0; cfg_burst_len = 8'd0;
    step();
    pulse_hw(); wait_idle();
    chk("R5 zero length", 64'(vcount), 64'd1);

    // R3: polarity 1 phase 0 with a slower clock
    tag = "R3"; vcount = 0;
    cfg_clk_div = 8'd3; cfg_burst_len = 8'd1; cfg_pre_dly = 8'd2; cfg_post_dly = 8'd0;
    step();
    pulse_hw(); wait_idle();
    chk("R3 conversions", 64'(vcount), 64'd1);

    summary();
    $finish;
  end
endmodule